// File: doc/BRIEF.md
# Machine Trap Entry and Return Controller

This block owns the machine-level trap registers of a 64-bit core and decides where the instruction stream goes next. Each cycle it looks at three things: a synchronous exception request from the pipeline, the three machine interrupt lines (software, timer and external), and a return-from-trap strobe. When it takes a trap, it fills in the cause, the trapping PC and the faulting value. It updates the interrupt-enable stack in the status register. One cycle later it issues a redirect to the handler address, with machine as the new privilege. On a return it issues a redirect to the saved PC, at the privilege held in the status register's previous-privilege field.

A small FSM drives the control. `ST_RUN` is the idle state, and it is the only state that accepts events. Taking a trap moves it to `ST_TRAP`, and a return moves it to `ST_RET`. Each of those two states lasts exactly one cycle, drives the redirect and then goes back to `ST_RUN`. Events presented while the FSM is in `ST_TRAP` or `ST_RET` are dropped, because the pipeline is being flushed. Software reaches the registers through a CSR port. A read is combinational and returns the old value, and a write lands at the clock edge, so a read and a write in the same cycle behave as an atomic swap.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset, redirect_valid_o is 0 and the status, mie, mtvec, mcause and mepc registers read zero.
- R2: CSR addresses are 0x300 status, 0x304 mie, 0x305 mtvec, 0x340 scratch, 0x341 mepc, 0x342 mcause and 0x343 mtval. A read returns the value held before any write in the same cycle, and a write is visible from the next cycle. In the status register only bit 3 (MIE), bit 7 (MPIE) and bits 12:11 (MPP) are writable. In mie only bits 3, 7 and 11 are writable. All other bits read 0.
- R3: A synchronous exception taken in ST_RUN redirects on the next cycle with privilege 2'b11 (machine). It sets mcause to {1'b0, code}, mepc to cur_pc_i and mtval to exc_tval_i.
- R4: An environment call (exc_ecall_i=1) records cause code 8 from user (2'b00), 9 from supervisor (2'b01) and 11 from machine (2'b11), and sets mtval to 0.
- R5: A taken interrupt sets mcause bit 63 to 1, with code 3 for software, 7 for timer and 11 for external, and sets mtval to 0.
- R6: An exception wins over any pending interrupt. Among interrupts, external wins first, then software, then timer.
- R7: mtvec bit 0 selects the mode and bit 1 always reads 0. In direct mode (bit 0 = 0), every trap targets BASE = mtvec with bits 1:0 cleared. In vectored mode (bit 0 = 1), interrupts target BASE + 4×code and exceptions still target BASE.
- R8: On trap entry, MPIE takes the old MIE, MIE clears and MPP takes the current privilege.
- R9: A return taken in ST_RUN redirects to mepc at privilege MPP, then sets MIE to MPIE, MPIE to 1 and MPP to user. If a trap is taken in the same cycle, the trap wins.
- R10: redirect_valid_o lasts one cycle (ST_TRAP or ST_RET), and any event presented during that cycle is ignored.
- R11: An interrupt is taken only when both its pending line and its mie bit are set, and either MIE is 1 or the privilege is below machine. When mie is zero, no interrupt is ever taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_ecall_i | input | 1 | The exception is an environment call |
| exc_code_i | input | 4 | Exception cause code (non-ecall) |
| cur_pc_i | input | 64 | PC of the trapping or interrupted instruction |
| exc_tval_i | input | 64 | Faulting value |
| irq_sw_i | input | 1 | Machine software interrupt pending |
| irq_tmr_i | input | 1 | Machine timer interrupt pending |
| irq_ext_i | input | 1 | Machine external interrupt pending |
| priv_i | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| mret_i | input | 1 | Return-from-trap strobe |
| csr_en_i | input | 1 | CSR access enable |
| csr_we_i | input | 1 | CSR write enable |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | CSR read data (old value) |
| redirect_valid_o | output | 1 | Redirect issued this cycle |
| redirect_pc_o | output | 64 | Redirect target |
| redirect_priv_o | output | 2 | Privilege after the redirect |

## Verification
The bench goes after several corner cases:
- All three interrupts pending while an exception arrives. A design with the priority wrong would report an interrupt cause or jump to a vector slot.
- An interrupt held pending in machine mode with MIE cleared, followed by the privilege dropping to supervisor. A design that ignored the privilege rule would either trap too early or never trap.
- A return strobe that coincides with an exception, and a second exception presented during the redirect cycle. Mishandling these would produce a return redirect, a double redirect or an overwritten mepc.
- A CSR swap on the scratch register, and a mode value of 2 written to mtvec. A design without the swap timing or the read-only bit would return the new value or leave vectoring in a reserved mode.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_TRAP = 2'd1,
        ST_RET  = 2'd2
    } tstate_e;

    localparam int CODE_W = 4;
    localparam int IRQ_N  = 3;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_IEN     = 12'h304;
    localparam logic [11:0] A_TVEC    = 12'h305;
    localparam logic [11:0] A_SCRATCH = 12'h340;
    localparam logic [11:0] A_EPC     = 12'h341;
    localparam logic [11:0] A_CAUSE   = 12'h342;
    localparam logic [11:0] A_TVAL    = 12'h343;

    localparam int B_MIE  = 3;
    localparam int B_MPIE = 7;
    localparam int B_MPP  = 11;

    localparam logic [CODE_W-1:0] CODE_SW    = 4'd3;
    localparam logic [CODE_W-1:0] CODE_TMR   = 4'd7;
    localparam logic [CODE_W-1:0] CODE_EXT   = 4'd11;
    localparam logic [CODE_W-1:0] CODE_ECALL = 4'd8;

    // index 0 is the highest interrupt priority
    localparam logic [CODE_W-1:0] IRQ_CODE [IRQ_N] = '{CODE_EXT, CODE_SW, CODE_TMR};

endpackage

// File: rtl/mtrap_arb.sv
module mtrap_arb
    import mtrap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              exc_valid_i,
    input  logic              exc_ecall_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [1:0]        priv_i,
    input  logic [IRQ_N-1:0]  pend_i,
    input  logic [IRQ_N-1:0]  en_i,
    input  logic              gie_i,
    input  logic [XLEN-1:0]   tvec_base_i,
    input  logic              tvec_vec_i,
    output logic              take_o,
    output logic              irq_o,
    output logic [CODE_W-1:0] code_o,
    output logic [XLEN-1:0]   target_o
);

    logic [IRQ_N-1:0]  live;
    logic              irq_any;
    logic              gate;
    logic [CODE_W-1:0] irq_code;

    // global gate: MIE set, or running below machine level
    assign gate    = gie_i || (priv_i != PRIV_M);
    assign live    = pend_i & en_i & {IRQ_N{gate}};
    assign irq_any = |live;

    // lowest index wins, so scan from the bottom of the priority list up
    always_comb begin
        irq_code = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (live[i]) irq_code = IRQ_CODE[i];
        end
    end

    always_comb begin
        take_o = exc_valid_i || irq_any;
        irq_o  = !exc_valid_i && irq_any;
        if (exc_valid_i) begin
            code_o = exc_ecall_i ? (CODE_ECALL + {2'b00, priv_i}) : exc_code_i;
        end else begin
            code_o = irq_code;
        end
        target_o = tvec_base_i;
        if (tvec_vec_i && irq_o) begin
            target_o = tvec_base_i + XLEN'({irq_code, 2'b00});
        end
    end

endmodule

// File: rtl/mtrap_csr.sv
module mtrap_csr
    import mtrap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              csr_en_i,
    input  logic              csr_we_i,
    input  logic [11:0]       csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    input  logic              trap_i,
    input  logic              trap_irq_i,
    input  logic [CODE_W-1:0] trap_code_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    input  logic [XLEN-1:0]   trap_tval_i,
    input  logic [1:0]        priv_i,
    input  logic              ret_i,
    output logic [XLEN-1:0]   tvec_base_o,
    output logic              tvec_vec_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              gie_o,
    output logic [1:0]        mpp_o,
    output logic [IRQ_N-1:0]  en_o
);

    localparam int PAD_W = XLEN - 1 - CODE_W;

    logic [XLEN-1:2]  tvec_base_q;
    logic             tvec_mode_q;
    logic [XLEN-1:0]  epc_q;
    logic [XLEN-1:0]  cause_q;
    logic [XLEN-1:0]  tval_q;
    logic [XLEN-1:0]  scratch_q;
    logic             st_mie_q;
    logic             st_mpie_q;
    logic [1:0]       st_mpp_q;
    logic [IRQ_N-1:0] en_q;

    logic             wr;
    logic [IRQ_N-1:0] en_wr;
    logic [XLEN-1:0]  en_rd;
    logic [XLEN-1:0]  st_rd;

    assign wr = csr_en_i && csr_we_i;

    for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
        assign en_wr[g] = csr_wdata_i[IRQ_CODE[g]];
    end

    always_comb begin
        en_rd = '0;
        for (int i = 0; i < IRQ_N; i++) en_rd[IRQ_CODE[i]] = en_q[i];
    end

    always_comb begin
        st_rd                 = '0;
        st_rd[B_MIE]          = st_mie_q;
        st_rd[B_MPIE]         = st_mpie_q;
        st_rd[B_MPP+1:B_MPP]  = st_mpp_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tvec_base_q <= '0;
            tvec_mode_q <= 1'b0;
            epc_q       <= '0;
            cause_q     <= '0;
            tval_q      <= '0;
            scratch_q   <= '0;
            st_mie_q    <= 1'b0;
            st_mpie_q   <= 1'b0;
            st_mpp_q    <= PRIV_U;
            en_q        <= '0;
        end else begin
            if (wr) begin
                case (csr_addr_i)
                    A_TVEC: begin
                        tvec_base_q <= csr_wdata_i[XLEN-1:2];
                        tvec_mode_q <= csr_wdata_i[0];
                    end
                    A_STATUS: begin
                        st_mie_q  <= csr_wdata_i[B_MIE];
                        st_mpie_q <= csr_wdata_i[B_MPIE];
                        st_mpp_q  <= csr_wdata_i[B_MPP+1:B_MPP];
                    end
                    A_IEN:     en_q      <= en_wr;
                    A_SCRATCH: scratch_q <= csr_wdata_i;
                    A_EPC:     epc_q     <= csr_wdata_i;
                    A_CAUSE:   cause_q   <= csr_wdata_i;
                    A_TVAL:    tval_q    <= csr_wdata_i;
                    default: ;
                endcase
            end
            // hardware events override a same-cycle software write
            if (trap_i) begin
                epc_q     <= trap_pc_i;
                cause_q   <= {trap_irq_i, {PAD_W{1'b0}}, trap_code_i};
                tval_q    <= trap_tval_i;
                st_mpie_q <= st_mie_q;
                st_mie_q  <= 1'b0;
                st_mpp_q  <= priv_i;
            end else if (ret_i) begin
                st_mie_q  <= st_mpie_q;
                st_mpie_q <= 1'b1;
                st_mpp_q  <= PRIV_U;
            end
        end
    end

    always_comb begin
        csr_rdata_o = '0;
        if (csr_en_i) begin
            case (csr_addr_i)
                A_TVEC:    csr_rdata_o = {tvec_base_q, 1'b0, tvec_mode_q};
                A_STATUS:  csr_rdata_o = st_rd;
                A_IEN:     csr_rdata_o = en_rd;
                A_SCRATCH: csr_rdata_o = scratch_q;
                A_EPC:     csr_rdata_o = epc_q;
                A_CAUSE:   csr_rdata_o = cause_q;
                A_TVAL:    csr_rdata_o = tval_q;
                default:   csr_rdata_o = '0;
            endcase
        end
    end

    assign tvec_base_o = {tvec_base_q, 2'b00};
    assign tvec_vec_o  = tvec_mode_q;
    assign epc_o       = epc_q;
    assign gie_o       = st_mie_q;
    assign mpp_o       = st_mpp_q;
    assign en_o        = en_q;

    // R8: entry stacks the enable bit and closes the global gate
    assert_entry_stack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> (!st_mie_q && (st_mpie_q == $past(st_mie_q))))
        else $error("trap entry did not stack MIE");

    // R9: after a return the previous level falls to user and MPIE is set
    assert_ret_unstack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_i |=> ((st_mpp_q == PRIV_U) && st_mpie_q))
        else $error("return did not unstack status");

endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              exc_valid_i,
    input  logic              exc_ecall_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic [XLEN-1:0]   exc_tval_i,
    input  logic              irq_sw_i,
    input  logic              irq_tmr_i,
    input  logic              irq_ext_i,
    input  logic [1:0]        priv_i,
    input  logic              mret_i,
    input  logic              csr_en_i,
    input  logic              csr_we_i,
    input  logic [11:0]       csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [1:0]        redirect_priv_o
);

    tstate_e           state_q, state_d;
    logic              accept;
    logic              arb_take, arb_irq;
    logic [CODE_W-1:0] arb_code;
    logic [XLEN-1:0]   arb_target;
    logic              trap_go, ret_go;
    logic [XLEN-1:0]   tval_eff;
    logic [XLEN-1:0]   tvec_base, epc;
    logic              tvec_vec, gie;
    logic [1:0]        mpp;
    logic [IRQ_N-1:0]  en, pend;
    logic [XLEN-1:0]   pc_q;
    logic [1:0]        priv_q;

    // pending lines in priority order: external, software, timer
    assign pend     = {irq_tmr_i, irq_sw_i, irq_ext_i};
    assign accept   = (state_q == ST_RUN);
    assign trap_go  = accept && arb_take;
    assign ret_go   = accept && mret_i && !arb_take;
    assign tval_eff = (exc_valid_i && !exc_ecall_i) ? exc_tval_i : '0;

    mtrap_arb #(.XLEN(XLEN)) u_arb (
        .exc_valid_i (exc_valid_i),
        .exc_ecall_i (exc_ecall_i),
        .exc_code_i  (exc_code_i),
        .priv_i      (priv_i),
        .pend_i      (pend),
        .en_i        (en),
        .gie_i       (gie),
        .tvec_base_i (tvec_base),
        .tvec_vec_i  (tvec_vec),
        .take_o      (arb_take),
        .irq_o       (arb_irq),
        .code_o      (arb_code),
        .target_o    (arb_target)
    );

    mtrap_csr #(.XLEN(XLEN)) u_csr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .csr_en_i    (csr_en_i),
        .csr_we_i    (csr_we_i),
        .csr_addr_i  (csr_addr_i),
        .csr_wdata_i (csr_wdata_i),
        .csr_rdata_o (csr_rdata_o),
        .trap_i      (trap_go),
        .trap_irq_i  (arb_irq),
        .trap_code_i (arb_code),
        .trap_pc_i   (cur_pc_i),
        .trap_tval_i (tval_eff),
        .priv_i      (priv_i),
        .ret_i       (ret_go),
        .tvec_base_o (tvec_base),
        .tvec_vec_o  (tvec_vec),
        .epc_o       (epc),
        .gie_o       (gie),
        .mpp_o       (mpp),
        .en_o        (en)
    );

    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                if (trap_go)     state_d = ST_TRAP;
                else if (ret_go) state_d = ST_RET;
                else             state_d = ST_RUN;
            end
            ST_TRAP: state_d = ST_RUN;
            ST_RET:  state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pc_q   <= '0;
            priv_q <= PRIV_M;
        end else if (trap_go) begin
            pc_q   <= arb_target;
            priv_q <= PRIV_M;
        end else if (ret_go) begin
            pc_q   <= epc;
            priv_q <= mpp;
        end
    end

    always_comb begin
        redirect_valid_o = 1'b0;
        unique case (state_q)
            ST_RUN:          redirect_valid_o = 1'b0;
            ST_TRAP, ST_RET: redirect_valid_o = 1'b1;
            default:         redirect_valid_o = 1'b0;
        endcase
        redirect_pc_o   = pc_q;
        redirect_priv_o = priv_q;
    end

    // R10: a redirect never lasts two cycles
    assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_valid_o |=> !redirect_valid_o)
        else $error("redirect held longer than one cycle");

    // R3: trap redirects always land in machine mode
    assert_trap_machine_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_TRAP) |-> (redirect_priv_o == PRIV_M))
        else $error("trap redirect not at machine level");

    // R11: an all-zero enable register blocks every interrupt
    assert_mask_all_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en == '0) |-> !arb_irq)
        else $error("interrupt chosen while fully masked");

    // R7: direct mode sends every trap to the base address
    assert_direct_base_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_go && !tvec_vec) |=> (redirect_pc_o == $past(tvec_base)))
        else $error("direct-mode target differs from base");

endmodule

// File: tb/mtrap_ctrl_tb.sv
module mtrap_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BASE = 64'h8000_0000;
    localparam logic [63:0] MSB  = 64'h8000_0000_0000_0000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        exc_valid_i = 0, exc_ecall_i = 0, mret_i = 0;
    logic [3:0]  exc_code_i = '0;
    logic [63:0] cur_pc_i = '0, exc_tval_i = '0;
    logic        irq_sw_i = 0, irq_tmr_i = 0, irq_ext_i = 0;
    logic [1:0]  priv_i = 2'b11;
    logic        csr_en_i = 0, csr_we_i = 0;
    logic [11:0] csr_addr_i = '0;
    logic [63:0] csr_wdata_i = '0;
    logic [63:0] csr_rdata_o;
    logic        redirect_valid_o;
    logic [63:0] redirect_pc_o;
    logic [1:0]  redirect_priv_o;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    mtrap_ctrl u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .exc_valid_i(exc_valid_i), .exc_ecall_i(exc_ecall_i), .exc_code_i(exc_code_i),
        .cur_pc_i(cur_pc_i), .exc_tval_i(exc_tval_i),
        .irq_sw_i(irq_sw_i), .irq_tmr_i(irq_tmr_i), .irq_ext_i(irq_ext_i),
        .priv_i(priv_i), .mret_i(mret_i),
        .csr_en_i(csr_en_i), .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
        .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
        .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
        .redirect_priv_o(redirect_priv_o)
    );

    typedef struct packed {
        logic [63:0] pc;
        logic [1:0]  priv;
    } redir_t;

    redir_t expq[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // scoreboard monitor: every redirect must match the oldest expected item
    always @(negedge clk_i) begin
        redir_t e;
        if (rst_ni && redirect_valid_o) begin
            if (expq.size() == 0) begin
                check(1'b0, "R10 unexpected redirect", redirect_pc_o, 64'h0);
            end else begin
                e = expq.pop_front();
                check(redirect_pc_o == e.pc, "R7 redirect target", redirect_pc_o, e.pc);
                check(redirect_priv_o == e.priv, "R3 R9 redirect privilege",
                      64'(redirect_priv_o), 64'(e.priv));
            end
        end
    end

    task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
        csr_en_i = 1; csr_we_i = 1; csr_addr_i = a; csr_wdata_i = d;
        @(negedge clk_i);
        csr_en_i = 0; csr_we_i = 0;
    endtask

    task automatic csr_check(input logic [11:0] a, input logic [63:0] exp, input string tag);
        csr_en_i = 1; csr_we_i = 0; csr_addr_i = a;
        #1;
        check(csr_rdata_o == exp, tag, csr_rdata_o, exp);
        csr_en_i = 0;
    endtask

    // drives one event cycle, then lets the redirect cycle pass
    task automatic fire(input logic exc, input logic ecall, input logic [3:0] code,
                        input logic [63:0] pc, input logic [63:0] tval, input logic [2:0] irq,
                        input logic [1:0] prv, input logic ret, input bit exp_r,
                        input logic [63:0] epc, input logic [1:0] eprv, input string tag);
        exc_valid_i = exc; exc_ecall_i = ecall; exc_code_i = code;
        cur_pc_i = pc; exc_tval_i = tval;
        {irq_ext_i, irq_sw_i, irq_tmr_i} = irq;
        priv_i = prv; mret_i = ret;
        if (exp_r) expq.push_back(redir_t'{pc: epc, priv: eprv});
        @(negedge clk_i);
        exc_valid_i = 0; exc_ecall_i = 0; mret_i = 0;
        {irq_ext_i, irq_sw_i, irq_tmr_i} = 3'b000;
        if (!exp_r) check(redirect_valid_o == 1'b0, tag, 64'(redirect_valid_o), 64'h0);
        @(negedge clk_i);
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        @(negedge clk_i);

        // R1 reset state
        check(redirect_valid_o == 1'b0, "R1 redirect idle", 64'(redirect_valid_o), 64'h0);
        csr_check(12'h300, 64'h0, "R1 status");
        csr_check(12'h304, 64'h0, "R1 mie");
        csr_check(12'h305, 64'h0, "R1 mtvec");
        csr_check(12'h342, 64'h0, "R1 mcause");
        csr_check(12'h341, 64'h0, "R1 mepc");

        // R2 access, swap and field masks
        csr_write(12'h305, BASE);
        csr_check(12'h305, BASE, "R2 mtvec write");
        csr_write(12'h340, 64'h1111);
        csr_en_i = 1; csr_we_i = 1; csr_addr_i = 12'h340; csr_wdata_i = 64'h2222;
        #1;
        check(csr_rdata_o == 64'h1111, "R2 swap returns old", csr_rdata_o, 64'h1111);
        @(negedge clk_i);
        csr_en_i = 0; csr_we_i = 0;
        csr_check(12'h340, 64'h2222, "R2 swap stores new");
        csr_write(12'h300, '1);
        csr_check(12'h300, 64'h1888, "R2 status mask");
        csr_write(12'h304, '1);
        csr_check(12'h304, 64'h888, "R2 mie mask");
        csr_write(12'h300, 64'h0);
        csr_write(12'h304, 64'h0);

        // R3 R8 illegal instruction from supervisor
        fire(1, 0, 4'd2, 64'h1000, 64'hdead, 3'b000, 2'b01, 0, 1, BASE, 2'b11, "R3");
        csr_check(12'h342, 64'd2, "R3 mcause");
        csr_check(12'h341, 64'h1000, "R3 mepc");
        csr_check(12'h343, 64'hdead, "R3 mtval");
        csr_check(12'h300, 64'h800, "R8 status after entry");

        // R9 return to supervisor
        fire(0, 0, 4'd0, 64'h0, 64'h0, 3'b000, 2'b11, 1, 1, 64'h1000, 2'b01, "R9");
        csr_check(12'h300, 64'h80, "R9 status after return");

        // R4 environment calls from each level
        fire(1, 1, 4'd0, 64'h2000, 64'h55, 3'b000, 2'b00, 0, 1, BASE, 2'b11, "R4");
        csr_check(12'h342, 64'd8, "R4 ecall user");
        csr_check(12'h343, 64'h0, "R4 ecall mtval");
        fire(1, 1, 4'd0, 64'h2004, 64'h55, 3'b000, 2'b01, 0, 1, BASE, 2'b11, "R4");
        csr_check(12'h342, 64'd9, "R4 ecall supervisor");
        fire(1, 1, 4'd0, 64'h2008, 64'h55, 3'b000, 2'b11, 0, 1, BASE, 2'b11, "R4");
        csr_check(12'h342, 64'd11, "R4 ecall machine");

        // R5 timer interrupt, direct mode
        csr_write(12'h304, 64'h888);
        csr_write(12'h300, 64'h8);
        fire(0, 0, 4'd0, 64'h3000, 64'h77, 3'b001, 2'b11, 0, 1, BASE, 2'b11, "R5");
        csr_check(12'h342, MSB | 64'd7, "R5 timer cause");
        csr_check(12'h343, 64'h0, "R5 mtval zero");
        csr_check(12'h300, 64'h1880, "R8 status machine entry");

        // R11 held timer with MIE clear in machine mode, then drop to supervisor
        irq_tmr_i = 1; priv_i = 2'b11;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_i);
            check(redirect_valid_o == 1'b0, "R11 gated in machine", 64'(redirect_valid_o), 64'h0);
        end
        priv_i = 2'b01;
        expq.push_back(redir_t'{pc: BASE, priv: 2'b11});
        @(negedge clk_i);
        irq_tmr_i = 0;
        @(negedge clk_i);
        csr_check(12'h342, MSB | 64'd7, "R11 taken below machine");

        // R6 R7 vectored mode
        csr_write(12'h305, BASE | 64'h1);
        csr_check(12'h305, BASE | 64'h1, "R7 vectored mode read");
        csr_write(12'h300, 64'h8);
        fire(0, 0, 4'd0, 64'h4000, 64'h0, 3'b111, 2'b11, 0, 1, BASE + 64'h2c, 2'b11, "R6");
        csr_check(12'h342, MSB | 64'd11, "R6 external first");
        csr_write(12'h300, 64'h8);
        fire(0, 0, 4'd0, 64'h4004, 64'h0, 3'b011, 2'b11, 0, 1, BASE + 64'hc, 2'b11, "R6");
        csr_check(12'h342, MSB | 64'd3, "R6 software over timer");
        csr_write(12'h300, 64'h8);
        fire(1, 0, 4'd13, 64'h4008, 64'h99, 3'b111, 2'b11, 0, 1, BASE, 2'b11, "R6");
        csr_check(12'h342, 64'd13, "R6 exception over interrupts");
        csr_check(12'h343, 64'h99, "R3 load fault mtval");

        // R11 all enables cleared
        csr_write(12'h304, 64'h0);
        csr_write(12'h300, 64'h8);
        fire(0, 0, 4'd0, 64'h5000, 64'h0, 3'b111, 2'b00, 0, 0, 64'h0, 2'b00, "R11 fully masked");
        csr_check(12'h342, 64'd13, "R11 mcause untouched");

        // R9 trap beats a same-cycle return
        fire(1, 0, 4'd15, 64'h6000, 64'h44, 3'b000, 2'b11, 1, 1, BASE, 2'b11, "R9");
        csr_check(12'h342, 64'd15, "R9 trap wins over return");
        csr_check(12'h341, 64'h6000, "R9 mepc of trap");

        // R10 event during the redirect cycle is dropped
        exc_valid_i = 1; exc_code_i = 4'd12; cur_pc_i = 64'h7000; exc_tval_i = 64'h1;
        expq.push_back(redir_t'{pc: BASE, priv: 2'b11});
        @(negedge clk_i);
        exc_code_i = 4'd2; cur_pc_i = 64'h7100;
        @(negedge clk_i);
        exc_valid_i = 0;
        @(negedge clk_i);
        check(redirect_valid_o == 1'b0, "R10 no second redirect", 64'(redirect_valid_o), 64'h0);
        csr_check(12'h341, 64'h7000, "R10 mepc kept");
        csr_check(12'h342, 64'd12, "R10 mcause kept");

        // R7 reserved mode bit reads zero
        csr_write(12'h305, BASE | 64'h2);
        csr_check(12'h305, BASE, "R7 mode bit1 zero");

        repeat (2) @(negedge clk_i);
        check(expq.size() == 0, "R10 all redirects seen", 64'(expq.size()), 64'h0);
        done = 1;
        finish_up();
    end
endmodule